// File: doc/BRIEF.md
# Processor Mode and Stack-Pointer Bank Controller

This block keeps the execution context of a small 32-bit microcontroller core. It tracks whether the core runs application code (thread mode) or services an exception (handler mode). It tracks whether thread code runs privileged, and which of two banked stack pointers is live. It also holds a three-bit control register, two exception-blocking mask bits and the number of the exception in service. The rest of the core drives exception entry and return strobes, special-register writes, interrupt enable and disable commands, a pulse for each executed floating-point instruction, and stack-pointer updates from push and pop. In return it reads the live stack pointer, the privilege and mode flags, and the blocking state.

The live stack pointer depends on two things: the mode, and one bit of the control register. Handler mode always uses the main pointer. Special-register writes and enable/disable commands are filtered by the current privilege. Every state change takes effect on the clock edge that samples the request and shows on the outputs right after that edge.

Top module: `core_mode_unit`

## Requirements
- R1: After reset the unit is in thread mode and privileged. The main pointer is live and holds the reset value `SP_RESET`. The control register, both mask bits and the exception number are 0.
- R2: In thread mode, control bit 1 selects the live pointer: 0 selects the main bank and 1 selects the process bank.
- R3: In handler mode the main bank is live whatever the value of control bit 1, and the unit is privileged whatever the value of control bit 0.
- R4: An `excEnter` pulse enters handler mode and latches `excNumIn`. An `excReturn` pulse returns to thread mode and sets the exception number to 0. When both pulses arrive in the same cycle, entry wins.
- R5: In thread mode, control bit 0 sets the privilege: 0 is privileged and 1 is unprivileged.
- R6: Special-register writes are ignored while the unit is unprivileged, and so are enable and disable commands. The `wrSel` targets are 0 for the main pointer, 1 for the process pointer, 2 for control, 3 for the interrupt mask and 4 for the fault mask.
- R7: An `fpExec` pulse sets control bit 2 at any privilege level. This holds even when a control write clears that bit in the same cycle.
- R8: The interrupt mask (bit 0 of a select-3 write) drives `cfgExcBlocked`. A disable command sets the mask and an enable command clears it. A command overrides a write in the same cycle, and a disable overrides an enable.
- R9: The fault mask (bit 0 of a select-4 write) drives both `cfgExcBlocked` and `allExcBlocked`.
- R10: Every value written into either stack pointer has bits [1:0] cleared.
- R11: An `spUpdEn` pulse loads `spUpdVal` into the live bank at any privilege level. A privileged special write to the same bank in the same cycle wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| excEnter | input | 1 | Exception entry strobe |
| excReturn | input | 1 | Exception return strobe |
| excNumIn | input | EXC_W | Number of the exception being entered |
| wrEn | input | 1 | Special-register write request |
| wrSel | input | 3 | Write target (see R6) |
| wrData | input | DATA_W | Write data |
| irqEnableCmd | input | 1 | Clear the interrupt mask |
| irqDisableCmd | input | 1 | Set the interrupt mask |
| fpExec | input | 1 | A floating-point instruction executed |
| spUpdEn | input | 1 | Stack operation updates the live pointer |
| spUpdVal | input | DATA_W | New live pointer value |
| activeSp | output | DATA_W | Live stack-pointer value |
| isPriv | output | 1 | Current code is privileged |
| inHandler | output | 1 | Handler mode |
| cfgExcBlocked | output | 1 | Configurable-priority exceptions blocked |
| allExcBlocked | output | 1 | Hard fault blocked as well |
| excNumOut | output | EXC_W | Exception in service (0 when unprivileged) |
| ctrlOut | output | 3 | Control register |

## Verification
A wrong mode bit or control bit shows on `activeSp` and `isPriv` on the very next cycle, because both are decoded from registers and not from inputs. A write that wrongly passed the privilege filter often stays hidden inside a bank that is not live. The bench therefore switches into handler mode after unprivileged writes and reads the main bank back through `activeSp`. A corrupted mask shows on the blocking outputs one cycle after the offending command.

// File: rtl/cmu_pkg.sv
package cmu_pkg;
  localparam int BANKS     = 2;
  localparam int BANK_MAIN = 0;
  localparam int BANK_PROC = 1;

  localparam int CTRL_W      = 3;
  localparam int CTRL_UNPRIV = 0;
  localparam int CTRL_PSEL   = 1;
  localparam int CTRL_FPCTX  = 2;

  typedef enum logic [2:0] {
    SEL_MAIN_SP    = 3'd0,
    SEL_PROC_SP    = 3'd1,
    SEL_CTRL       = 3'd2,
    SEL_IRQ_MASK   = 3'd3,
    SEL_FAULT_MASK = 3'd4
  } reg_sel_e;

  // strobes from control to datapath
  typedef struct packed {
    logic [BANKS-1:0] ldSp;
    logic [BANKS-1:0] spFromPush;
    logic             ldCtrl;
    logic             setFpCtx;
    logic             ldIrqMask;
    logic             setIrqMask;
    logic             clrIrqMask;
    logic             ldFaultMask;
    logic             ldExcNum;
    logic             clrExcNum;
  } strobe_t;
endpackage

// File: rtl/cmu_ctrl.sv
module cmu_ctrl
  import cmu_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              excEnter,
  input  logic              excReturn,
  input  logic              wrEn,
  input  logic [2:0]        wrSel,
  input  logic              irqEnableCmd,
  input  logic              irqDisableCmd,
  input  logic              fpExec,
  input  logic              spUpdEn,
  input  logic [CTRL_W-1:0] ctrlQ,
  output strobe_t           strobe,
  output logic              inHandler,
  output logic              isPriv,
  output logic              activeBank
);
  logic handlerQ;
  logic wrOk;

  always_ff @(posedge clk) begin
    if (!rstN)          handlerQ <= 1'b0;
    else if (excEnter)  handlerQ <= 1'b1;
    else if (excReturn) handlerQ <= 1'b0;
  end

  assign inHandler  = handlerQ;
  assign isPriv     = handlerQ | ~ctrlQ[CTRL_UNPRIV];
  assign activeBank = (handlerQ | ~ctrlQ[CTRL_PSEL]) ? 1'(BANK_MAIN) : 1'(BANK_PROC);
  assign wrOk       = wrEn & isPriv;

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    localparam logic [2:0] BANK_SEL = (b == BANK_MAIN) ? SEL_MAIN_SP : SEL_PROC_SP;
    logic wrHit, pushHit;
    assign wrHit   = wrOk && (wrSel == BANK_SEL);
    assign pushHit = spUpdEn && (activeBank == 1'(b));
    assign strobe.ldSp[b]       = wrHit | pushHit;
    assign strobe.spFromPush[b] = ~wrHit;
  end

  assign strobe.ldCtrl      = wrOk && (wrSel == SEL_CTRL);
  assign strobe.setFpCtx    = fpExec;
  assign strobe.ldIrqMask   = wrOk && (wrSel == SEL_IRQ_MASK);
  assign strobe.setIrqMask  = isPriv & irqDisableCmd;
  assign strobe.clrIrqMask  = isPriv & irqEnableCmd;
  assign strobe.ldFaultMask = wrOk && (wrSel == SEL_FAULT_MASK);
  assign strobe.ldExcNum    = excEnter;
  assign strobe.clrExcNum   = excReturn & ~excEnter;
endmodule

// File: rtl/cmu_dpath.sv
module cmu_dpath
  import cmu_pkg::*;
#(
  parameter int                DATA_W   = 32,
  parameter int                EXC_W    = 9,
  parameter logic [DATA_W-1:0] SP_RESET = 32'h2000_1000
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobe,
  input  logic              activeBank,
  input  logic [DATA_W-1:0] wrData,
  input  logic [DATA_W-1:0] spUpdVal,
  input  logic [EXC_W-1:0]  excNumIn,
  output logic [DATA_W-1:0] activeSp,
  output logic [CTRL_W-1:0] ctrlQ,
  output logic              irqMaskQ,
  output logic              faultMaskQ,
  output logic [EXC_W-1:0]  excNumQ
);
  localparam int                ALIGN_BITS = $clog2(DATA_W / 8);
  localparam logic [DATA_W-1:0] ALIGN_MASK = ~((DATA_W)'((1 << ALIGN_BITS) - 1));

  logic [DATA_W-1:0] spQ [BANKS];

  for (genvar b = 0; b < BANKS; b++) begin : g_sp
    localparam logic [DATA_W-1:0] RST_VAL = (b == BANK_MAIN) ? (SP_RESET & ALIGN_MASK) : '0;
    logic [DATA_W-1:0] src;
    assign src = strobe.spFromPush[b] ? spUpdVal : wrData;
    always_ff @(posedge clk) begin
      if (!rstN)               spQ[b] <= RST_VAL;
      else if (strobe.ldSp[b]) spQ[b] <= src & ALIGN_MASK;
    end
  end

  assign activeSp = spQ[activeBank];

  logic [CTRL_W-1:0] ctrlNext;
  logic              irqNext;
  always_comb begin
    ctrlNext = strobe.ldCtrl ? wrData[CTRL_W-1:0] : ctrlQ;
    if (strobe.setFpCtx) ctrlNext[CTRL_FPCTX] = 1'b1;
    irqNext = strobe.ldIrqMask ? wrData[0] : irqMaskQ;
    if (strobe.clrIrqMask) irqNext = 1'b0;
    if (strobe.setIrqMask) irqNext = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlQ      <= '0;
      irqMaskQ   <= 1'b0;
      faultMaskQ <= 1'b0;
      excNumQ    <= '0;
    end else begin
      ctrlQ    <= ctrlNext;
      irqMaskQ <= irqNext;
      if (strobe.ldFaultMask) faultMaskQ <= wrData[0];
      if (strobe.ldExcNum)       excNumQ <= excNumIn;
      else if (strobe.clrExcNum) excNumQ <= '0;
    end
  end
endmodule

// File: rtl/core_mode_unit.sv
module core_mode_unit
  import cmu_pkg::*;
#(
  parameter int                DATA_W   = 32,
  parameter int                EXC_W    = 9,
  parameter logic [DATA_W-1:0] SP_RESET = 32'h2000_1000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              excEnter,
  input  logic              excReturn,
  input  logic [EXC_W-1:0]  excNumIn,
  input  logic              wrEn,
  input  logic [2:0]        wrSel,
  input  logic [DATA_W-1:0] wrData,
  input  logic              irqEnableCmd,
  input  logic              irqDisableCmd,
  input  logic              fpExec,
  input  logic              spUpdEn,
  input  logic [DATA_W-1:0] spUpdVal,
  output logic [DATA_W-1:0] activeSp,
  output logic              isPriv,
  output logic              inHandler,
  output logic              cfgExcBlocked,
  output logic              allExcBlocked,
  output logic [EXC_W-1:0]  excNumOut,
  output logic [2:0]        ctrlOut
);
  strobe_t           strobe;
  logic              activeBank;
  logic [CTRL_W-1:0] ctrlQ;
  logic              irqMaskQ, faultMaskQ;
  logic [EXC_W-1:0]  excNumQ;

  cmu_ctrl u_ctrl (
    .clk, .rstN, .excEnter, .excReturn, .wrEn, .wrSel,
    .irqEnableCmd, .irqDisableCmd, .fpExec, .spUpdEn,
    .ctrlQ, .strobe, .inHandler, .isPriv, .activeBank
  );

  cmu_dpath #(.DATA_W(DATA_W), .EXC_W(EXC_W), .SP_RESET(SP_RESET)) u_dpath (
    .clk, .rstN, .strobe, .activeBank, .wrData, .spUpdVal, .excNumIn,
    .activeSp, .ctrlQ, .irqMaskQ, .faultMaskQ, .excNumQ
  );

  assign ctrlOut       = ctrlQ;
  assign cfgExcBlocked = irqMaskQ | faultMaskQ;
  assign allExcBlocked = faultMaskQ;
  assign excNumOut     = isPriv ? excNumQ : '0;
endmodule

// File: rtl/cmu_chk.sv
module cmu_chk #(
  parameter int DATA_W = 32,
  parameter int EXC_W  = 9
) (
  input logic              clk,
  input logic              rstN,
  input logic              excEnter,
  input logic              excReturn,
  input logic [EXC_W-1:0]  excNumIn,
  input logic              wrEn,
  input logic [2:0]        wrSel,
  input logic [DATA_W-1:0] wrData,
  input logic              irqEnableCmd,
  input logic              irqDisableCmd,
  input logic              fpExec,
  input logic              spUpdEn,
  input logic [DATA_W-1:0] spUpdVal,
  input logic [DATA_W-1:0] activeSp,
  input logic              isPriv,
  input logic              inHandler,
  input logic              cfgExcBlocked,
  input logic              allExcBlocked,
  input logic [EXC_W-1:0]  excNumOut,
  input logic [2:0]        ctrlOut
);
  assert_handler_priv_R3: assert property (@(posedge clk) disable iff (!rstN)
    inHandler |-> isPriv);

  assert_enter_R4: assert property (@(posedge clk) disable iff (!rstN)
    excEnter |=> (inHandler && excNumOut == $past(excNumIn)));

  assert_return_R4: assert property (@(posedge clk) disable iff (!rstN)
    (excReturn && !excEnter) |=> (!inHandler && excNumOut == '0));

  assert_unpriv_ctrl_R6: assert property (@(posedge clk) disable iff (!rstN)
    (!isPriv && wrEn && wrSel == 3'd2 && !fpExec) |=> $stable(ctrlOut));

  assert_unpriv_mask_R6: assert property (@(posedge clk) disable iff (!rstN)
    !isPriv |=> ($stable(cfgExcBlocked) && $stable(allExcBlocked)));

  assert_fp_set_R7: assert property (@(posedge clk) disable iff (!rstN)
    fpExec |=> ctrlOut[2]);

  assert_disable_R8: assert property (@(posedge clk) disable iff (!rstN)
    (isPriv && irqDisableCmd) |=> cfgExcBlocked);

  assert_fault_R9: assert property (@(posedge clk) disable iff (!rstN)
    allExcBlocked |-> cfgExcBlocked);

  assert_align_R10: assert property (@(posedge clk) disable iff (!rstN)
    activeSp[1:0] == 2'b00);
endmodule

bind core_mode_unit cmu_chk #(.DATA_W(DATA_W), .EXC_W(EXC_W)) u_chk (.*);

// File: tb/core_mode_unit_bench.sv
`timescale 1ns/1ps
module core_mode_unit_bench;
  localparam int DATA_W = 32;
  localparam int EXC_W  = 9;
  localparam logic [31:0] SPR = 32'h2000_1000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic excEnter = 0, excReturn = 0, wrEn = 0, irqEnableCmd = 0, irqDisableCmd = 0;
  logic fpExec = 0, spUpdEn = 0;
  logic [EXC_W-1:0]  excNumIn = '0;
  logic [2:0]        wrSel = '0;
  logic [DATA_W-1:0] wrData = '0, spUpdVal = '0;
  logic [DATA_W-1:0] activeSp;
  logic isPriv, inHandler, cfgExcBlocked, allExcBlocked;
  logic [EXC_W-1:0] excNumOut;
  logic [2:0] ctrlOut;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 0;

  always #2.5 clk = ~clk;

  core_mode_unit #(.DATA_W(DATA_W), .EXC_W(EXC_W), .SP_RESET(SPR)) u_core_mode_unit (.*);

  typedef struct packed {
    logic        ent, ret;
    logic [8:0]  exN;
    logic        we;
    logic [2:0]  sel;
    logic [31:0] dat;
    logic        en, dis, fp, su;
    logic [31:0] suv;
    logic [31:0] eSp;
    logic        ePriv, eHand, eCfg, eAll;
    logic [8:0]  eExc;
    logic [2:0]  eCtrl;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t VEC [NV] = '{
    // R10 process pointer written unaligned
    '{0,0,9'd0, 1,3'd1,32'h2000_0803, 0,0,0,0,32'h0, SPR,1,0,0,0,9'd0,3'd0, 4'd10},
    // R2 select process bank
    '{0,0,9'd0, 1,3'd2,32'h2, 0,0,0,0,32'h0, 32'h2000_0800,1,0,0,0,9'd0,3'd2, 4'd2},
    // R11 stack update hits process bank
    '{0,0,9'd0, 0,3'd0,32'h0, 0,0,0,1,32'h2000_07F6, 32'h2000_07F4,1,0,0,0,9'd0,3'd2, 4'd11},
    // R3 entry forces main bank
    '{1,0,9'd15, 0,3'd0,32'h0, 0,0,0,0,32'h0, SPR,1,1,0,0,9'd15,3'd2, 4'd3},
    // R11 stack update in handler hits main bank
    '{0,0,9'd0, 0,3'd0,32'h0, 0,0,0,1,32'h2000_0FE0, 32'h2000_0FE0,1,1,0,0,9'd15,3'd2, 4'd11},
    // R8 disable command
    '{0,0,9'd0, 0,3'd0,32'h0, 0,1,0,0,32'h0, 32'h2000_0FE0,1,1,1,0,9'd15,3'd2, 4'd8},
    // R9 fault mask write
    '{0,0,9'd0, 1,3'd4,32'h1, 0,0,0,0,32'h0, 32'h2000_0FE0,1,1,1,1,9'd15,3'd2, 4'd9},
    // R9 clear fault mask with R8 enable command
    '{0,0,9'd0, 1,3'd4,32'h0, 1,0,0,0,32'h0, 32'h2000_0FE0,1,1,0,0,9'd15,3'd2, 4'd9},
    // R4 return to thread, process bank again
    '{0,1,9'd0, 0,3'd0,32'h0, 0,0,0,0,32'h0, 32'h2000_07F4,1,0,0,0,9'd0,3'd2, 4'd4},
    // R5 drop privilege
    '{0,0,9'd0, 1,3'd2,32'h3, 0,0,0,0,32'h0, 32'h2000_07F4,0,0,0,0,9'd0,3'd3, 4'd5},
    // R6 unprivileged main pointer write ignored (seen in row 14)
    '{0,0,9'd0, 1,3'd0,32'h1234_5678, 0,0,0,0,32'h0, 32'h2000_07F4,0,0,0,0,9'd0,3'd3, 4'd6},
    // R6 unprivileged disable ignored
    '{0,0,9'd0, 0,3'd0,32'h0, 0,1,0,0,32'h0, 32'h2000_07F4,0,0,0,0,9'd0,3'd3, 4'd6},
    // R7 fp pulse sets bit 2, ctrl write ignored (R6)
    '{0,0,9'd0, 1,3'd2,32'h0, 0,0,1,0,32'h0, 32'h2000_07F4,0,0,0,0,9'd0,3'd7, 4'd7},
    // R6 main bank unchanged, R3 privileged in handler
    '{1,0,9'd11, 0,3'd0,32'h0, 0,0,0,0,32'h0, 32'h2000_0FE0,1,1,0,0,9'd11,3'd7, 4'd6},
    // R4 entry wins over return
    '{1,1,9'd5, 0,3'd0,32'h0, 0,0,0,0,32'h0, 32'h2000_0FE0,1,1,0,0,9'd5,3'd7, 4'd4},
    // R3 handler writes control
    '{0,0,9'd0, 1,3'd2,32'h0, 0,0,0,0,32'h0, 32'h2000_0FE0,1,1,0,0,9'd5,3'd0, 4'd3},
    // R4 return
    '{0,1,9'd0, 0,3'd0,32'h0, 0,0,0,0,32'h0, 32'h2000_0FE0,1,0,0,0,9'd0,3'd0, 4'd4},
    // R5 unprivileged on main bank
    '{0,0,9'd0, 1,3'd2,32'h1, 0,0,0,0,32'h0, 32'h2000_0FE0,0,0,0,0,9'd0,3'd1, 4'd5},
    // R3 entry from unprivileged thread
    '{1,0,9'd3, 0,3'd0,32'h0, 0,0,0,0,32'h0, 32'h2000_0FE0,1,1,0,0,9'd3,3'd1, 4'd3},
    // R5 return restores unprivileged thread
    '{0,1,9'd0, 0,3'd0,32'h0, 0,0,0,0,32'h0, 32'h2000_0FE0,0,0,0,0,9'd0,3'd1, 4'd5}
  };

  task automatic idle();
    excEnter = 0; excReturn = 0; excNumIn = '0; wrEn = 0; wrSel = '0; wrData = '0;
    irqEnableCmd = 0; irqDisableCmd = 0; fpExec = 0; spUpdEn = 0; spUpdVal = '0;
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string tag, input logic [31:0] eSp, input logic ePriv,
                       input logic eHand, input logic eCfg, input logic eAll,
                       input logic [8:0] eExc, input logic [2:0] eCtrl);
    nChecks++;
    if (activeSp !== eSp || isPriv !== ePriv || inHandler !== eHand ||
        cfgExcBlocked !== eCfg || allExcBlocked !== eAll ||
        excNumOut !== eExc || ctrlOut !== eCtrl) begin
      nFails++;
      $display("FAIL %s: got sp=%h priv=%b hand=%b cfg=%b all=%b exc=%0d ctrl=%b exp sp=%h priv=%b hand=%b cfg=%b all=%b exc=%0d ctrl=%b",
               tag, activeSp, isPriv, inHandler, cfgExcBlocked, allExcBlocked, excNumOut, ctrlOut,
               eSp, ePriv, eHand, eCfg, eAll, eExc, eCtrl);
    end
  endtask

  initial begin
    idle();
    rstN = 0;
    repeat (3) tick();
    // R1 reset state
    check("R1 reset", SPR, 1, 0, 0, 0, 9'd0, 3'd0);
    rstN = 1;
    tick();
    check("R1 idle after reset", SPR, 1, 0, 0, 0, 9'd0, 3'd0);

    for (int i = 0; i < NV; i++) begin
      excEnter = VEC[i].ent; excReturn = VEC[i].ret; excNumIn = VEC[i].exN;
      wrEn = VEC[i].we; wrSel = VEC[i].sel; wrData = VEC[i].dat;
      irqEnableCmd = VEC[i].en; irqDisableCmd = VEC[i].dis; fpExec = VEC[i].fp;
      spUpdEn = VEC[i].su; spUpdVal = VEC[i].suv;
      tick();
      check($sformatf("R%0d vector %0d", VEC[i].req, i), VEC[i].eSp, VEC[i].ePriv,
            VEC[i].eHand, VEC[i].eCfg, VEC[i].eAll, VEC[i].eExc, VEC[i].eCtrl);
    end
    idle();

    // R1 reset in the middle of a run
    rstN = 0;
    tick();
    check("R1 mid-run reset", SPR, 1, 0, 0, 0, 9'd0, 3'd0);
    rstN = 1;
    tick();

    // R8 enable and disable together: disable wins
    irqEnableCmd = 1; irqDisableCmd = 1;
    tick(); idle();
    check("R8 disable beats enable", SPR, 1, 0, 1, 0, 9'd0, 3'd0);

    // R8 mask write clears
    wrEn = 1; wrSel = 3'd3; wrData = 32'h0;
    tick(); idle();
    check("R8 mask write clear", SPR, 1, 0, 0, 0, 9'd0, 3'd0);

    // R8 command overrides write in same cycle
    wrEn = 1; wrSel = 3'd3; wrData = 32'h0; irqDisableCmd = 1;
    tick(); idle();
    check("R8 command beats write", SPR, 1, 0, 1, 0, 9'd0, 3'd0);

    // R11 special write beats stack update on the same bank; R10 alignment
    wrEn = 1; wrSel = 3'd0; wrData = 32'h3000_0007; spUpdEn = 1; spUpdVal = 32'h4000_0000;
    tick(); idle();
    check("R11 write beats push", 32'h3000_0004, 1, 0, 1, 0, 9'd0, 3'd0);

    // R7 fp pulse and clearing control write together
    wrEn = 1; wrSel = 3'd2; wrData = 32'h0; fpExec = 1;
    tick(); idle();
    check("R7 fp with ctrl write", 32'h3000_0004, 1, 0, 1, 0, 9'd0, 3'd4);

    done = 1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: all requirements, got hung run, expected completion");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end
endmodule